// File: doc/BRIEF.md
# NAND Block-Erase Sequencer

This block sits on the host side of a parallel NAND interface and carries out one block erase. A single-cycle `start` with a 16-bit block address starts it. It then selects the device and writes four bytes on the shared bus, each qualified as a command or as an address. These are the erase-setup command, the low and the high block-address byte, and the erase-confirm command. After that it waits out a short guard interval and watches the ready line until the device finishes.

Once the device is ready again, the sequencer writes the status-read command and pulses the read strobe once. It keeps bit 0 of the returned byte as its verdict. It then pulses `done` for one cycle, with `fail` showing the result. If the ready line never returns within a parameterised number of cycles, the sequencer gives up and reports a failure without reading status.

Every strobe phase lasts a programmable number of clock cycles. That count is raised automatically to a floor derived from the clock period and the minimum write-cycle time. This keeps write strobes far enough apart even when the programmed count is zero.

Top module: `nand_erase_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1; `nand_cle`, `nand_ale`, `nand_dout_en`, `busy` and `done` are 0.
- R2: The write strobes carry, in order: 60h with `nand_cle`=1, `blk_addr[7:0]` with `nand_ale`=1, `blk_addr[15:8]` with `nand_ale`=1, D0h with `nand_cle`=1, then 70h with `nand_cle`=1. A command byte never has `nand_ale` set, and an address byte never has `nand_cle` set.
- R3: `nand_dout`, `nand_cle` and `nand_ale` do not change while `nand_we_n` is low, nor in the cycle in which it returns high.
- R4: Let the effective pulse P be the larger of `strobe_cyc` and ceil(TWC_NS/(3·CLK_NS)), and at least 1. P is captured at launch. Each write strobe is low for exactly P cycles, and successive strobes among the first four bytes fall exactly 3·P cycles apart. No two falls are ever closer than ceil(TWC_NS/CLK_NS) cycles.
- R5: `nand_rdy` is ignored for the hold phase of the confirm byte and GUARD_CYC further cycles. A device that is still reporting ready at that time does not trigger the status command.
- R6: The 70h byte is written only after `nand_rdy`=1 has been seen during polling. It is followed by exactly one read strobe, low for P cycles, with `nand_din` sampled in its last low cycle.
- R7: `done` is high for exactly one cycle per erase. With it, `fail` equals bit 0 of the status byte (1 = erase failed), and `fail` holds until the next launch.
- R8: If `nand_rdy` stays low for TMO_CYC cycles after the guard interval, the sequencer finishes with `fail`=1. No 70h byte and no read strobe are issued.
- R9: `start` has no effect while `busy` is high. `busy` rises only in the cycle after an accepted `start` and stays high through the `done` cycle.
- R10: `nand_ce_n` is low exactly while `busy` is high. `nand_dout_en` is high only during write phases, never during a read strobe.
- R11: `nand_we_n` and `nand_re_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| blk_addr | input | 16 | Block address; low byte issued first |
| strobe_cyc | input | PW_W | Requested cycles per strobe phase |
| nand_rdy | input | 1 | Device ready (1) / busy (0) |
| nand_din | input | 8 | Data bus from device |
| nand_dout | output | 8 | Data bus to device |
| nand_dout_en | output | 1 | Host drives the data bus |
| nand_cle | output | 1 | Command-latch qualifier |
| nand_ale | output | 1 | Address-latch qualifier |
| nand_ce_n | output | 1 | Device select, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Verdict of the last erase |

## Verification
The assertions check on every cycle:
- bus stability around each write strobe and the write-cycle floor between strobe falls;
- mutual exclusion of the two strobes;
- the single-cycle `done`, and that `busy` is entered only from a `start` and held until `done`.

Only the bench's scenarios can show the rest. A device model records every latched byte and drives the ready line and the status byte. With it the bench checks the byte order and qualifiers, the exact strobe widths for random pulse counts, and that a device which stays ready for a while after the confirm byte does not trigger a premature status read. It also checks the verdict taken from status bit 0 and the timeout path when the device never becomes ready.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

  localparam int unsigned BLK_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHOLD,
    ST_GUARD,
    ST_POLL,
    ST_RLOW,
    ST_RHOLD,
    ST_FIN
  } seq_state_e;

  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
  localparam logic [7:0] OP_STATUS      = 8'h70;

  localparam logic [2:0] SLOT_CONFIRM = 3'd3;
  localparam logic [2:0] SLOT_STATUS  = 3'd4;

  typedef struct packed {
    logic [7:0] data;
    logic       cle;
    logic       ale;
  } bus_word_t;

  // Byte and qualifier for each position of the write sequence.
  function automatic bus_word_t slot_word(input logic [2:0] slot, input logic [BLK_W-1:0] blk);
    bus_word_t w;
    w = '{data: 8'h00, cle: 1'b0, ale: 1'b0};
    case (slot)
      3'd0:    w = '{data: OP_ERASE_SETUP, cle: 1'b1, ale: 1'b0};
      3'd1:    w = '{data: blk[7:0],       cle: 1'b0, ale: 1'b1};
      3'd2:    w = '{data: blk[15:8],      cle: 1'b0, ale: 1'b1};
      3'd3:    w = '{data: OP_ERASE_GO,    cle: 1'b1, ale: 1'b0};
      3'd4:    w = '{data: OP_STATUS,      cle: 1'b1, ale: 1'b0};
      default: w = '{data: 8'h00,          cle: 1'b0, ale: 1'b0};
    endcase
    return w;
  endfunction

  // Smallest phase length so that three phases cover the write-cycle time.
  function automatic int unsigned min_pulse(input int unsigned twc_ns, input int unsigned clk_ns);
    int unsigned v;
    v = (twc_ns + 3 * clk_ns - 1) / (3 * clk_ns);
    return (v == 0) ? 1 : v;
  endfunction

  // Requested phase length raised to the floor.
  function automatic int unsigned eff_pulse(input int unsigned req, input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

  // Shortest legal distance, in cycles, between two write-strobe falls.
  function automatic int unsigned min_wc_cycles(input int unsigned twc_ns, input int unsigned clk_ns);
    return (twc_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/nand_erase_phase_tmr.sv
module nand_erase_phase_tmr #(
  parameter int unsigned PW_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [PW_W-1:0] len,
  output logic            last
);
  logic [PW_W-1:0] cnt_q;

  assign last = (cnt_q == len - PW_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (!last) begin
      cnt_q <= cnt_q + PW_W'(1);
    end
  end
endmodule

// File: rtl/nand_erase_wait_tmr.sv
module nand_erase_wait_tmr #(
  parameter int unsigned GUARD_CYC = 4,
  parameter int unsigned TMO_CYC   = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic guard_done,
  output logic expired
);
  localparam int unsigned LIMIT = GUARD_CYC + TMO_CYC;
  localparam int unsigned CW    = $clog2(LIMIT + 2);

  logic [CW-1:0] cnt_q;

  assign guard_done = (cnt_q >= CW'(GUARD_CYC));
  assign expired    = (cnt_q >= CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned TWC_NS    = 50,
  parameter int unsigned PW_W      = 4,
  parameter int unsigned GUARD_CYC = 4,
  parameter int unsigned TMO_CYC   = 50000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [15:0]     blk_addr,
  input  logic [PW_W-1:0] strobe_cyc,
  input  logic            nand_rdy,
  input  logic [7:0]      nand_din,
  output logic [7:0]      nand_dout,
  output logic            nand_dout_en,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_ce_n,
  output logic            nand_we_n,
  output logic            nand_re_n,
  output logic            busy,
  output logic            done,
  output logic            fail
);
  localparam int unsigned MIN_PW = min_pulse(TWC_NS, CLK_NS);

  seq_state_e            state_q, state_d;
  logic [2:0]            slot_q, slot_d;
  logic [BLK_W-1:0]      addr_q, addr_d;
  logic [PW_W-1:0]       pw_q, pw_d;
  logic                  fail_q, fail_d;

  // Named internal events
  logic      launch;
  logic      phase_last;
  logic      phase_restart;
  logic      guard_done;
  logic      wait_expired;
  logic      arm_wait;
  logic      wait_run;
  logic      status_sample;
  logic      wr_phase_d;
  bus_word_t word_d;

  assign launch        = start && (state_q == ST_IDLE);
  assign phase_restart = (state_d != state_q);
  assign status_sample = (state_q == ST_RLOW) && phase_last;
  assign arm_wait      = (state_q == ST_WHOLD) && (state_d == ST_GUARD);
  assign wait_run      = (state_q == ST_GUARD) || (state_q == ST_POLL);

  nand_erase_phase_tmr #(.PW_W(PW_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_restart),
    .len     (pw_q),
    .last    (phase_last)
  );

  nand_erase_wait_tmr #(.GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm_wait),
    .run        (wait_run),
    .guard_done (guard_done),
    .expired    (wait_expired)
  );

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    addr_d  = addr_q;
    pw_d    = pw_q;
    fail_d  = fail_q;
    case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d = ST_WSET;
          slot_d  = 3'd0;
          addr_d  = blk_addr;
          pw_d    = PW_W'(eff_pulse(int'(strobe_cyc), MIN_PW));
          fail_d  = 1'b0;
        end
      end
      ST_WSET:  if (phase_last) state_d = ST_WLOW;
      ST_WLOW:  if (phase_last) state_d = ST_WHOLD;
      ST_WHOLD: begin
        if (phase_last) begin
          if (slot_q == SLOT_CONFIRM) begin
            state_d = ST_GUARD;
          end else if (slot_q == SLOT_STATUS) begin
            state_d = ST_RLOW;
          end else begin
            slot_d  = slot_q + 3'd1;
            state_d = ST_WSET;
          end
        end
      end
      ST_GUARD: if (guard_done) state_d = ST_POLL;
      ST_POLL: begin
        if (nand_rdy) begin
          slot_d  = SLOT_STATUS;
          state_d = ST_WSET;
        end else if (wait_expired) begin
          fail_d  = 1'b1;
          state_d = ST_FIN;
        end
      end
      ST_RLOW: begin
        if (status_sample) begin
          fail_d  = nand_din[0];
          state_d = ST_RHOLD;
        end
      end
      ST_RHOLD: if (phase_last) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign word_d     = slot_word(slot_d, addr_d);
  assign wr_phase_d = (state_d == ST_WSET) || (state_d == ST_WLOW) || (state_d == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      slot_q       <= 3'd0;
      addr_q       <= '0;
      pw_q         <= PW_W'(1);
      fail_q       <= 1'b0;
      nand_dout    <= 8'h00;
      nand_dout_en <= 1'b0;
      nand_cle     <= 1'b0;
      nand_ale     <= 1'b0;
      nand_we_n    <= 1'b1;
      nand_re_n    <= 1'b1;
      nand_ce_n    <= 1'b1;
    end else begin
      state_q      <= state_d;
      slot_q       <= slot_d;
      addr_q       <= addr_d;
      pw_q         <= pw_d;
      fail_q       <= fail_d;
      nand_dout    <= wr_phase_d ? word_d.data : 8'h00;
      nand_dout_en <= wr_phase_d;
      nand_cle     <= wr_phase_d && word_d.cle;
      nand_ale     <= wr_phase_d && word_d.ale;
      nand_we_n    <= (state_d != ST_WLOW);
      nand_re_n    <= (state_d != ST_RLOW);
      nand_ce_n    <= (state_d == ST_IDLE);
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);
  assign fail = fail_q;

endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk
  import nand_erase_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned TWC_NS = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_dout,
  input logic       nand_cle,
  input logic       nand_ale
);
  localparam int unsigned MIN_WC = min_wc_cycles(TWC_NS, CLK_NS);
  localparam int unsigned GW     = $clog2(MIN_WC + 2);

  logic          we_prev_q;
  logic [GW-1:0] gap_q;
  logic          we_fall;

  assign we_fall = we_prev_q && !nand_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_prev_q <= 1'b1;
      gap_q     <= GW'(MIN_WC);
    end else begin
      we_prev_q <= nand_we_n;
      if (we_fall) begin
        gap_q <= GW'(1);
      end else if (gap_q < GW'(MIN_WC)) begin
        gap_q <= gap_q + GW'(1);
      end
    end
  end

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> ($stable(nand_dout) && $stable(nand_cle) && $stable(nand_ale)));

  // R3
  strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> ($stable(nand_dout) && $stable(nand_cle) && $stable(nand_ale)));

  // R4
  wr_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_fall |-> (gap_q >= GW'(MIN_WC)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind nand_erase_seq nand_erase_seq_chk #(.CLK_NS(CLK_NS), .TWC_NS(TWC_NS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .nand_we_n (nand_we_n),
  .nand_re_n (nand_re_n),
  .nand_dout (nand_dout),
  .nand_cle  (nand_cle),
  .nand_ale  (nand_ale)
);

// File: tb/sim_nand_erase_seq.sv
module sim_nand_erase_seq;
  localparam int CLK_NS    = 20;
  localparam int TWC_NS    = 50;
  localparam int PW_W      = 4;
  localparam int GUARD_CYC = 4;
  localparam int TMO_CYC   = 300;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [15:0]     blk_addr = 16'h0000;
  logic [PW_W-1:0] strobe_cyc = '0;
  logic            nand_rdy = 1'b1;
  logic [7:0]      nand_din;
  logic [7:0]      nand_dout;
  logic            nand_dout_en, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;
  logic            busy, done, fail;

  always #10 clk = ~clk;

  nand_erase_seq #(.CLK_NS(CLK_NS), .TWC_NS(TWC_NS), .PW_W(PW_W),
                   .GUARD_CYC(GUARD_CYC), .TMO_CYC(TMO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr), .strobe_cyc(strobe_cyc),
    .nand_rdy(nand_rdy), .nand_din(nand_din), .nand_dout(nand_dout), .nand_dout_en(nand_dout_en),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .busy(busy), .done(done), .fail(fail));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_pw(input int cfg);
    int fl;
    fl = (TWC_NS + 3 * CLK_NS - 1) / (3 * CLK_NS);
    if (fl < 1) fl = 1;
    return (cfg > fl) ? cfg : fl;
  endfunction

  // {data, cle, ale} expected at each latched position
  function automatic logic [9:0] exp_word(input int k, input logic [15:0] a);
    case (k)
      0: return {8'h60, 2'b10};
      1: return {a[7:0], 2'b01};
      2: return {a[15:8], 2'b01};
      3: return {8'hD0, 2'b10};
      4: return {8'h70, 2'b10};
      default: return 10'h000;
    endcase
  endfunction

  // device model state
  logic [7:0] st_byte = 8'h00;
  int busy_len = 1;
  bit hang = 1'b0;
  int pw_e = 1;
  logic [9:0] cap [8];
  int cap_n = 0, wlow = 0, gap = 0, wid_bad = 0, gap_bad = 0, re_falls = 0;
  int overlap_bad = 0, oe_bad = 0, ph = 0, lat = 0, left = 0;
  bit early70 = 1'b0;
  logic we_p = 1'b1, re_p = 1'b1;

  assign nand_din = nand_re_n ? 8'h00 : st_byte;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n && !nand_re_n) overlap_bad++;
      if (!nand_re_n && nand_dout_en) oe_bad++;
      gap++;
      if (!nand_we_n) wlow++;
      if (we_p && !nand_we_n) begin
        if (cap_n >= 1 && cap_n <= 3 && gap != 3 * pw_e) gap_bad++;
        gap = 0;
      end
      if (!we_p && nand_we_n) begin
        if (wlow != pw_e) wid_bad++;
        wlow = 0;
        if (cap_n < 8) cap[cap_n] = {nand_dout, nand_cle, nand_ale};
        cap_n++;
        if (nand_cle && nand_dout == 8'hD0) begin
          ph = 1;
          lat = pw_e + 2;
        end
        if (nand_cle && nand_dout == 8'h70 && ph != 3) early70 = 1'b1;
      end
      if (re_p && !nand_re_n) re_falls++;
      case (ph)
        1: begin
          lat--;
          if (lat <= 0) begin
            nand_rdy = 1'b0;
            ph = 2;
            left = busy_len;
          end
        end
        2: begin
          left--;
          if (left <= 0 && !hang) begin
            nand_rdy = 1'b1;
            ph = 3;
          end
        end
        default: ;
      endcase
      we_p = nand_we_n;
      re_p = nand_re_n;
    end
  end

  task automatic run_op(input logic [15:0] addr, input int cfg, input logic [7:0] status,
                        input int blen, input bit hng);
    int n;
    bit exp_fail;
    @(negedge clk);
    st_byte = status; busy_len = blen; hang = hng; pw_e = exp_pw(cfg);
    cap_n = 0; wlow = 0; gap = 0; wid_bad = 0; gap_bad = 0; re_falls = 0;
    overlap_bad = 0; oe_bad = 0; ph = 0; early70 = 1'b0; nand_rdy = 1'b1;
    start = 1'b1; blk_addr = addr; strobe_cyc = PW_W'(cfg);
    @(negedge clk);
    start = 1'b0; blk_addr = ~addr; strobe_cyc = PW_W'(cfg + 1);
    repeat (4) @(negedge clk);
    chk(busy && !nand_ce_n, "R10", "busy/select during run", {busy, nand_ce_n}, 2'b10);
    start = 1'b1;   // must be ignored (R9)
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    exp_fail = hng ? 1'b1 : status[0];
    chk(done, "R9", "done reached", done, 1);
    chk(fail == exp_fail, hng ? "R8" : "R7", "verdict", fail, exp_fail);
    chk(cap_n == (hng ? 4 : 5), "R2", "strobe count", cap_n, hng ? 4 : 5);
    for (int k = 0; k < 5 && k < cap_n && k < 8; k++)
      chk(cap[k] == exp_word(k, addr), "R2", "latched byte", cap[k], exp_word(k, addr));
    chk(wid_bad == 0 && gap_bad == 0, "R4", "strobe width/gap errors", wid_bad + gap_bad, 0);
    chk(!early70, "R5", "status command before busy ended", early70, 0);
    chk(re_falls == (hng ? 0 : 1), "R6", "read strobes", re_falls, hng ? 0 : 1);
    chk(overlap_bad == 0, "R11", "strobe overlap", overlap_bad, 0);
    chk(oe_bad == 0, "R10", "bus driven during read", oe_bad, 0);
    if (hng) chk(n > TMO_CYC, "R8", "timeout length", n, TMO_CYC);
    @(negedge clk);
    chk(!done && !busy && nand_ce_n && fail == exp_fail, "R7", "after done",
        {done, busy, nand_ce_n, fail}, {3'b001, exp_fail});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dout_en && !busy && !done,
        "R1", "in reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dout_en, busy, done},
        8'b11100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dout_en && !busy && !done,
        "R1", "after reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dout_en, busy, done},
        8'b11100000);
    // directed corners
    run_op(16'h0000, 0, 8'h00, 1, 1'b0);
    run_op(16'hFFFF, 5, 8'hFF, 40, 1'b0);
    run_op(16'hA55A, 1, 8'hFE, 10, 1'b0);
    run_op(16'h1234, 2, 8'h01, 5, 1'b1);
    run_op(16'h00FF, 3, 8'hC0, 2, 1'b0);
    // constrained random
    for (int i = 0; i < 30; i++) begin
      run_op(16'($urandom), int'($urandom_range(0, 5)), 8'($urandom),
             int'($urandom_range(1, 60)), ($urandom_range(0, 9) == 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule